// File: doc/BRIEF.md
# Hash Input Block Staging Buffer

This block sits in front of a hash engine whose input is a FIFO of 32-bit words. Message bytes arrive one at a time and are gathered in a 64-byte holding queue. The block passes them on as words only in amounts that let the engine's chaining state be captured and resumed later. A non-final request forwards data only up to a 64-byte block boundary, counting the bytes already held. A final request forwards everything down to a 4-byte boundary and leaves the last 0 to 3 bytes for the padding stage. The engine and the padding are outside this block.

A request gives the number of new bytes and whether it is final. Bytes then stream in, words stream out, and a one-cycle done pulse marks the end. The block counts the bytes it has sent to the engine. It can also be loaded from a saved total byte count, followed by the bytes that were held when the state was saved. The saved state is read back as a total count, a flag for "nothing sent yet", and the held bytes through a read port. The engine FIFO holds a fixed number of words. Once that many words have been sent, the block asks for the current free space before it sends more.

Top module: `hash_block_stager`

## Requirements
- R1: After reset the block is idle (`req_ready`=1), holds no bytes, has sent 0 bytes, and drives `out_valid`=0 and `in_ready`=0.
- R2: A non-final request where held plus new bytes total fewer than 64 appends every new byte to the queue and emits no word.
- R3: A non-final request forwards the largest multiple of 64 of (held + new) bytes and keeps the remainder, which is always below 64 (60 held + 60 new gives 16 words and 56 held). Each word carries 4 consecutive stream bytes, the oldest in bits 7:0.
- R4: A final request forwards the largest multiple of 4 of (held + new) bytes, which may be zero new bytes, and leaves 0 to 3 bytes held.
- R5: `sent_bytes` grows by exactly 4 for each accepted word, and `save_total` always equals `sent_bytes` plus `held_len`.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: After a request starts, at most FIFO_WORDS words are accepted. When that credit is used up and words are still owed, `space_req` rises. Each `space_valid` answered while `space_req` is high grants exactly `space_words` more words.
- R8: A load with total T sets `sent_bytes` to T with its low 6 bits cleared, clears the queue, and then takes T mod 64 bytes into the queue.
- R9: `save_fresh` is 1 exactly when `sent_bytes` is 0. The engine must then be seeded with its initial constants, not a saved state.
- R10: A non-final request of zero bytes produces a done pulse and changes no state.
- R11: A request for which `req_nbytes` + `held_len` does not fit in 32 bits raises `req_err` for one cycle and changes no state.
- R12: `rd_byte` returns the held byte at position `rd_idx`, where index 0 is the oldest held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_final | input | 1 | Request is the final one of the message |
| req_nbytes | input | 32 | Number of new bytes the request brings |
| req_ready | output | 1 | Block is idle and takes a request or load |
| req_done | output | 1 | One-cycle pulse when a request or load completes |
| req_err | output | 1 | One-cycle pulse when a request is rejected for overflow |
| ld_valid | input | 1 | Load saved state, taken when idle and no request is present |
| ld_total | input | 32 | Saved total byte count |
| in_valid | input | 1 | Message byte valid |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| out_valid | output | 1 | Word for the engine FIFO valid |
| out_data | output | 32 | Word for the engine, oldest byte in bits 7:0 |
| out_ready | input | 1 | Engine FIFO accepts the word |
| space_req | output | 1 | Credit exhausted, free space count wanted |
| space_valid | input | 1 | Free space count supplied |
| space_words | input | 6 | Free word count of the engine FIFO |
| sent_bytes | output | 32 | Bytes sent to the engine |
| held_len | output | 7 | Bytes held in the queue (0 to 64) |
| save_total | output | 32 | Total byte count for saving state |
| save_fresh | output | 1 | Nothing sent yet, engine uses initial constants |
| rd_idx | input | 6 | Held byte index to read |
| rd_byte | output | 8 | Held byte at rd_idx |

## Verification
A wrong remaining-byte or forward count shows up at the end of the request it corrupts. The done pulse then arrives with the wrong number of words, or with `held_len` off the expected remainder, and `sent_bytes` moves away from the model at once. A fault in the queue shift order shows up on the first word: bytes are swapped or repeated in `out_data`, or the held bytes read back through `rd_byte` are wrong. A faulty credit counter is seen within FIFO_WORDS words, either as an extra word before `space_req` or as the wrong number of space requests.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } hbs_state_e;
endpackage

// File: rtl/hbs_byte_queue.sv
module hbs_byte_queue #(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  input  logic [IW-1:0] rd_idx,
  output logic [LW-1:0] len,
  output logic [31:0]   head_word,
  output logic [7:0]    rd_byte
);
  logic [7:0]    q_r [DEPTH];
  logic [7:0]    q_d [DEPTH];
  logic [LW-1:0] len_q, len_d, wr_pos;
  logic          q_en;

  assign wr_pos = pop ? (len_q - LW'(4)) : len_q;
  assign q_en   = push | pop;

  always_comb begin
    len_d = len_q;
    if (clr) begin
      len_d = '0;
    end else begin
      if (pop)  len_d = len_d - LW'(4);
      if (push) len_d = len_d + LW'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [7:0] shifted;
    if (i + 4 < DEPTH) begin : g_mid
      assign shifted = pop ? q_r[i+4] : q_r[i];
    end else begin : g_top
      assign shifted = q_r[i];
    end
    always_comb begin
      q_d[i] = shifted;
      if (push && (wr_pos == LW'(i))) q_d[i] = push_data;
    end
    always_ff @(posedge clk) begin
      if (q_en) q_r[i] <= q_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  assign len       = len_q;
  assign head_word = {q_r[3], q_r[2], q_r[1], q_r[0]};
  assign rd_byte   = q_r[rd_idx];
endmodule

// File: rtl/hbs_credit.sv
module hbs_credit #(
  parameter int WORDS = 32,
  parameter int SW    = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          grant_valid,
  input  logic [SW-1:0] grant_words,
  input  logic          take,
  output logic          credit_ok
);
  logic [SW-1:0] cred_q, cred_d;
  logic          cred_en;

  always_comb begin
    cred_d = cred_q;
    if (reload)           cred_d = SW'(WORDS);
    else if (grant_valid) cred_d = grant_words;
    else if (take)        cred_d = cred_q - SW'(1);
  end

  assign cred_en = reload | grant_valid | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cred_q <= SW'(WORDS);
    else if (cred_en) cred_q <= cred_d;
  end

  assign credit_ok = (cred_q != '0);
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl
  import hbs_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BLK   = 64,
  parameter int LW    = $clog2(BLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_final,
  input  logic [CNT_W-1:0] req_nbytes,
  input  logic             ld_valid,
  input  logic [CNT_W-1:0] ld_total,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [LW-1:0]    len,
  input  logic             credit_ok,
  output logic             req_ready,
  output logic             req_done,
  output logic             req_err,
  output logic             in_ready,
  output logic             out_valid,
  output logic             space_req,
  output logic             push,
  output logic             pop,
  output logic             clr,
  output logic             reload,
  output logic [CNT_W-1:0] sent
);
  localparam int BW = $clog2(BLK);
  localparam logic [CNT_W-1:0] BLK_MASK  = ~CNT_W'(BLK - 1);
  localparam logic [CNT_W-1:0] WORD_MASK = ~CNT_W'(3);

  hbs_state_e       state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] fwd_q, fwd_d;
  logic [CNT_W-1:0] sent_q, sent_d;
  logic             done_q, done_d, err_q, err_d;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] fwd_calc;
  logic             run, cnt_en;

  assign run       = (state_q == ST_RUN);
  assign req_ready = ~run;
  assign in_ready  = run && (remain_q != '0) && (len < LW'(BLK));
  assign push      = in_ready && in_valid;
  assign out_valid = run && (fwd_q != '0) && (len >= LW'(4)) && credit_ok;
  assign pop       = out_valid && out_ready;
  assign space_req = run && (fwd_q != '0) && !credit_ok;
  assign sum       = {1'b0, req_nbytes} + (CNT_W+1)'(len);
  assign fwd_calc  = sum[CNT_W-1:0] & (req_final ? WORD_MASK : BLK_MASK);

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    fwd_d    = fwd_q;
    sent_d   = sent_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    clr      = 1'b0;
    reload   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (sum[CNT_W]) begin
            err_d = 1'b1;
          end else if ((req_nbytes == '0) && !req_final) begin
            done_d = 1'b1;
          end else begin
            state_d  = ST_RUN;
            remain_d = req_nbytes;
            fwd_d    = fwd_calc;
            reload   = 1'b1;
          end
        end else if (ld_valid) begin
          state_d  = ST_RUN;
          remain_d = CNT_W'(ld_total[BW-1:0]);
          fwd_d    = '0;
          sent_d   = ld_total & BLK_MASK;
          clr      = 1'b1;
        end
      end
      default: begin
        if (push) remain_d = remain_q - CNT_W'(1);
        if (pop) begin
          fwd_d  = fwd_q - CNT_W'(4);
          sent_d = sent_q + CNT_W'(4);
        end
        if ((remain_q == '0) && (fwd_q == '0)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
    endcase
  end

  assign cnt_en = run | req_valid | ld_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      fwd_q    <= '0;
      sent_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (cnt_en) begin
        remain_q <= remain_d;
        fwd_q    <= fwd_d;
        sent_q   <= sent_d;
      end
    end
  end

  assign req_done = done_q;
  assign req_err  = err_q;
  assign sent     = sent_q;
endmodule

// File: rtl/hash_block_stager.sv
module hash_block_stager #(
  parameter int CNT_W      = 32,
  parameter int BLK_BYTES  = 64,
  parameter int FIFO_WORDS = 32,
  localparam int LW = $clog2(BLK_BYTES + 1),
  localparam int IW = $clog2(BLK_BYTES),
  localparam int SW = $clog2(FIFO_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_final,
  input  logic [CNT_W-1:0] req_nbytes,
  output logic             req_ready,
  output logic             req_done,
  output logic             req_err,
  input  logic             ld_valid,
  input  logic [CNT_W-1:0] ld_total,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  input  logic             out_ready,
  output logic             space_req,
  input  logic             space_valid,
  input  logic [SW-1:0]    space_words,
  output logic [CNT_W-1:0] sent_bytes,
  output logic [LW-1:0]    held_len,
  output logic [CNT_W-1:0] save_total,
  output logic             save_fresh,
  input  logic [IW-1:0]    rd_idx,
  output logic [7:0]       rd_byte
);
  logic          push, pop, clr, reload, credit_ok;
  logic [LW-1:0] len;

  hbs_ctrl #(.CNT_W(CNT_W), .BLK(BLK_BYTES), .LW(LW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_final  (req_final),
    .req_nbytes (req_nbytes),
    .ld_valid   (ld_valid),
    .ld_total   (ld_total),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .len        (len),
    .credit_ok  (credit_ok),
    .req_ready  (req_ready),
    .req_done   (req_done),
    .req_err    (req_err),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .space_req  (space_req),
    .push       (push),
    .pop        (pop),
    .clr        (clr),
    .reload     (reload),
    .sent       (sent_bytes)
  );

  hbs_byte_queue #(.DEPTH(BLK_BYTES), .LW(LW), .IW(IW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push      (push),
    .push_data (in_data),
    .pop       (pop),
    .rd_idx    (rd_idx),
    .len       (len),
    .head_word (out_data),
    .rd_byte   (rd_byte)
  );

  hbs_credit #(.WORDS(FIFO_WORDS), .SW(SW)) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .reload      (reload),
    .grant_valid (space_req & space_valid),
    .grant_words (space_words),
    .take        (pop),
    .credit_ok   (credit_ok)
  );

  assign held_len   = len;
  assign save_total = sent_bytes + CNT_W'(len);
  assign save_fresh = (sent_bytes == '0);
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
  parameter int CNT_W      = 32,
  parameter int BLK_BYTES  = 64,
  parameter int FIFO_WORDS = 32,
  parameter int LW = $clog2(BLK_BYTES + 1),
  parameter int SW = $clog2(FIFO_WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_final,
  input logic             req_ready,
  input logic             req_done,
  input logic             req_err,
  input logic             ld_valid,
  input logic             out_valid,
  input logic [31:0]      out_data,
  input logic             out_ready,
  input logic             space_req,
  input logic             space_valid,
  input logic [SW-1:0]    space_words,
  input logic [CNT_W-1:0] sent_bytes,
  input logic [LW-1:0]    held_len
);
  logic [SW:0]   used_q;
  logic [SW-1:0] grant_q;
  logic          fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= '0;
      grant_q <= SW'(FIFO_WORDS);
      fin_q   <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        used_q  <= '0;
        grant_q <= SW'(FIFO_WORDS);
        fin_q   <= req_final;
      end else if (space_req && space_valid) begin
        used_q  <= '0;
        grant_q <= space_words;
      end else if (out_valid && out_ready) begin
        used_q  <= used_q + (SW+1)'(1);
      end
      if (ld_valid && req_ready && !req_valid) fin_q <= 1'b0;
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  sent_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (sent_bytes == $past(sent_bytes) + CNT_W'(4)));

  // R7
  credit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (used_q < (SW+1)'(grant_q)));

  // R11
  reject_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ((held_len == $past(held_len)) && (sent_bytes == $past(sent_bytes))));

  // R4
  final_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && fin_q) |-> (held_len < LW'(4)));

  // R3
  held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_len <= LW'(BLK_BYTES));
endmodule

bind hash_block_stager hbs_checker #(
  .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES), .FIFO_WORDS(FIFO_WORDS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_final   (req_final),
  .req_ready   (req_ready),
  .req_done    (req_done),
  .req_err     (req_err),
  .ld_valid    (ld_valid),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_ready   (out_ready),
  .space_req   (space_req),
  .space_valid (space_valid),
  .space_words (space_words),
  .sent_bytes  (sent_bytes),
  .held_len    (held_len)
);

// File: tb/hash_block_stager_test.sv
`timescale 1ns/1ps
module hash_block_stager_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_final = 1'b0;
  logic [31:0] req_nbytes = '0;
  logic        req_ready, req_done, req_err;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_total = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_ready = 1'b0;
  logic [31:0] out_data;
  logic        space_req, space_valid = 1'b0;
  logic [5:0]  space_words = '0;
  logic [31:0] sent_bytes, save_total;
  logic [6:0]  held_len;
  logic        save_fresh;
  logic [5:0]  rd_idx = '0;
  logic [7:0]  rd_byte;

  hash_block_stager uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0]  feed_mem [256];
  int          feed_n = 0, feed_i = 0;
  bit          feed_take = 0;
  logic [31:0] got_w [256];
  int          got_n = 0;
  bit          bp_mode = 0;
  int          rdy_cnt = 0;
  bit          stall_pend = 0;
  logic [31:0] stall_word = '0;
  int          stall_bad = 0, stall_seen = 0;
  logic [5:0]  sp_val = 6'd8;
  int          sp_cnt = 0;
  bit          done_seen = 0, err_seen = 0;
  logic [7:0]  exp_held [64];
  int          exp_len = 0;
  longint      exp_sent = 0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (feed_take) feed_i++;
    in_valid  = (feed_i < feed_n);
    in_data   = (feed_i < feed_n) ? feed_mem[feed_i] : 8'h00;
    feed_take = in_valid && in_ready;
    rdy_cnt++;
    out_ready = bp_mode ? ((rdy_cnt % 3) != 0) : 1'b1;
    if (stall_pend && out_valid && (out_data != stall_word)) stall_bad++;
    stall_pend = out_valid && !out_ready;
    stall_word = out_data;
    if (stall_pend) stall_seen++;
    if (out_valid && out_ready) begin
      if (got_n < 256) got_w[got_n] = out_data;
      got_n++;
    end
    if (space_valid) space_valid = 1'b0;
    else if (space_req) begin
      space_valid = 1'b1;
      space_words = sp_val;
      sp_cnt++;
    end
    if (req_done) done_seen = 1;
    if (req_err)  err_seen = 1;
  end

  task automatic wait_end();
    int n = 0;
    while (!done_seen && !err_seen && n < 3000) begin
      @(posedge clk);
      n++;
    end
    @(posedge clk); #1;
  endtask

  task automatic check_state(input string req);
    int bad = 0;
    chk(held_len == 7'(exp_len), req, "held_len", held_len, exp_len);
    chk(sent_bytes == 32'(exp_sent), req, "sent_bytes", sent_bytes, exp_sent);
    // R5: save_total is sent plus held
    chk(save_total == 32'(exp_sent + exp_len), "R5", "save_total", save_total, exp_sent + exp_len);
    for (int i = 0; i < exp_len; i++) begin
      rd_idx = 6'(i);
      #0.1;
      if (rd_byte != exp_held[i]) bad++;
    end
    // R12: held bytes read back oldest first
    chk(bad == 0, "R12", "held byte mismatches", bad, 0);
  endtask

  task automatic run_req(input int n, input bit fin, input int base, input string req);
    logic [7:0] strm [320];
    int total, fwd, bad, nw;
    for (int i = 0; i < exp_len; i++) strm[i] = exp_held[i];
    for (int i = 0; i < n; i++) strm[exp_len+i] = 8'(base + i);
    total = exp_len + n;
    if (!fin && n == 0) fwd = 0;
    else fwd = fin ? (total & ~3) : (total & ~63);
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) feed_mem[i] = 8'(base + i);
    feed_i = 0; feed_n = n; got_n = 0; sp_cnt = 0;
    stall_bad = 0; stall_seen = 0;
    done_seen = 0; err_seen = 0;
    req_valid = 1'b1; req_final = fin; req_nbytes = 32'(n);
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_end();
    chk(done_seen, req, "done pulse", done_seen, 1);
    nw = fwd / 4;
    chk(got_n == nw, req, "word count", got_n, nw);
    bad = 0;
    for (int k = 0; k < nw && k < got_n; k++) begin
      if (got_w[k] != {strm[4*k+3], strm[4*k+2], strm[4*k+1], strm[4*k]}) begin
        if (bad == 0) chk(0, req, "word value", got_w[k],
                          {strm[4*k+3], strm[4*k+2], strm[4*k+1], strm[4*k]});
        bad++;
      end
    end
    if (bad == 0) chk(1, req, "word values", 0, 0);
    exp_sent += fwd;
    exp_len = total - fwd;
    for (int i = 0; i < exp_len; i++) exp_held[i] = strm[fwd+i];
    check_state(req);
  endtask

  task automatic test_reset();
    // R1 and R9 after reset
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(held_len == 7'd0, "R1", "held_len", held_len, 0);
    chk(sent_bytes == 32'd0, "R1", "sent_bytes", sent_bytes, 0);
    chk(!out_valid && !in_ready, "R1", "out_valid|in_ready", out_valid | in_ready, 0);
    chk(save_fresh == 1'b1, "R9", "save_fresh at start", save_fresh, 1);
  endtask

  task automatic test_append();
    run_req(60, 0, 8'h10, "R2");
    chk(save_fresh == 1'b1, "R9", "save_fresh with nothing sent", save_fresh, 1);
  endtask

  task automatic test_block();
    bp_mode = 1;
    run_req(60, 0, 8'h80, "R3");
    bp_mode = 0;
    // R6: stalled words held stable
    chk(stall_seen > 0 && stall_bad == 0, "R6", "stall stability errors", stall_bad, 0);
    chk(save_fresh == 1'b0, "R9", "save_fresh after send", save_fresh, 0);
  endtask

  task automatic test_noop();
    run_req(0, 0, 0, "R10");
  endtask

  task automatic test_overflow();
    @(posedge clk); #1;
    done_seen = 0; err_seen = 0; got_n = 0; feed_n = 0; feed_i = 0;
    req_valid = 1'b1; req_final = 1'b0; req_nbytes = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_end();
    chk(err_seen && !done_seen, "R11", "err pulse", err_seen, 1);
    chk(got_n == 0, "R11", "words after reject", got_n, 0);
    check_state("R11");
  endtask

  task automatic test_final();
    run_req(5, 1, 8'h40, "R4");
  endtask

  task automatic test_load();
    @(posedge clk); #1;
    for (int i = 0; i < 7; i++) feed_mem[i] = 8'(8'hA0 + i);
    feed_i = 0; feed_n = 7; got_n = 0; done_seen = 0; err_seen = 0;
    ld_valid = 1'b1; ld_total = 32'd327;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    wait_end();
    chk(done_seen, "R8", "load done", done_seen, 1);
    exp_sent = 320;
    exp_len = 7;
    for (int i = 0; i < 7; i++) exp_held[i] = 8'(8'hA0 + i);
    check_state("R8");
  endtask

  task automatic test_credit();
    sp_val = 6'd8;
    run_req(200, 0, 8'h00, "R7");
    // R7: 48 words, 32 initial credit, two grants of 8
    chk(sp_cnt == 2, "R7", "space queries", sp_cnt, 2);
  endtask

  task automatic test_final_empty();
    run_req(0, 1, 0, "R4");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    test_reset();
    test_append();
    test_block();
    test_noop();
    test_overflow();
    test_final();
    test_load();
    test_credit();
    test_final_empty();
    finish_up();
  end
endmodule